// File: doc/BRIEF.md
# I2C Condition Monitor with Interrupt Flags

This block runs beside an I2C transfer engine and watches the two bus wires. Each wire is resynchronised into the local clock. The block then picks out start conditions (data falling while the clock is high) and stop conditions (data rising while the clock is high). It counts clock rising edges after each start, which tells it where every condition falls inside a nine-bit frame (eight data bits plus the acknowledge bit). A condition that lands where the protocol does not allow one is declared a bus error. A stop seen while the engine reports master mode is also a bus error.

The block keeps three sticky flags: transfer complete, bus error and stop. Each flag has its own enable bit. A flag latches on its event whatever its enable holds, and only the enable decides whether the flag reaches an interrupt line. Software reads all six bits through one register and clears a flag by writing 0 to it. A bus error raises a halt line to the engine, and the line stays high until software clears the bus-error flag. The engine supplies a one-cycle transfer-done pulse and a one-cycle arbitration-lost pulse.

Top module: `i2c_evt_mon`

## Requirements
- R1: After reset the six register bits read 0, and `xferIrq`, `stopIrq` and `halt` are low.
- R2: A `xferDone` pulse sets the transfer flag (register bit 3) whatever the value of its enable.
- R3: The register layout is: bit 0 transfer enable, bit 1 bus-error enable, bit 2 stop enable, bit 3 transfer flag, bit 4 bus-error flag, bit 5 stop flag. `xferIrq` is (bit3 and bit0) or (bit4 and bit1). `stopIrq` is bit5 and bit2.
- R4: A register write loads bits 2:0 into the enables. A 0 written to a flag bit clears that flag. A 1 written to a flag bit leaves it unchanged.
- R5: If a flag's set event and a clearing write land in the same cycle, the flag ends up set.
- R6: A stop condition (SDA rising while SCL is high) sets the stop flag. A start condition (SDA falling while SCL is high) does not set it.
- R7: A stop condition while `masterMode` is high is a bus error, wherever it falls in the frame.
- R8: During the first frame after a start, a start or stop after one or more SCL rising edges is a bus error. A stop before any SCL rising edge is not.
- R9: In later frames, a start or stop after two to eight SCL rising edges into the frame is a bus error. One after zero or one rising edge (the frame boundary and the first bit slot) is not.
- R10: A bus error sets the bus-error flag whatever its enable and raises `halt`. `halt` stays high until the bus-error flag is cleared.
- R11: An `arbLost` pulse sets the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL wire level |
| sdaIn | input | 1 | Raw SDA wire level |
| masterMode | input | 1 | High while the engine acts as bus master |
| xferDone | input | 1 | One-cycle pulse when the engine finishes a transfer |
| arbLost | input | 1 | One-cycle pulse when the engine loses arbitration |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 6 | Register write data (layout in R3) |
| regRdata | output | 6 | Register read data (layout in R3) |
| xferIrq | output | 1 | Transfer interrupt request (completion or bus error) |
| stopIrq | output | 1 | Stop interrupt request |
| halt | output | 1 | Stops the transfer engine after a bus error |

## Verification
A wrong bit counter or a wrong first-frame marker shifts where the legal window falls. The error then shows as a bus-error flag and `halt` that appear, or fail to appear, three clocks after the offending SDA edge. The bench sweeps every rising-edge count in both the first frame and a later frame, with both condition types and both master states, so a counter that is off by one changes the result of a neighbouring case. A faulty flag merge shows in the register read the cycle after the write or the event.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int REG_W       = 6;
  localparam int EN_XFER     = 0;
  localparam int EN_BER      = 1;
  localparam int EN_STOP     = 2;
  localparam int FL_XFER     = 3;
  localparam int FL_BER      = 4;
  localparam int FL_STOP     = 5;
  localparam int FLAG_N      = 3;

  // Conditions seen on the synchronised bus wires
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
  } busCondT;

  // Strobes from control into the flag datapath
  typedef struct packed {
    logic setBer;
    logic setStop;
  } ctrlStrobeT;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_mon_datapath.sv
module i2c_mon_datapath
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             xferDone,
  input  logic             arbLost,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWdata,
  input  ctrlStrobeT       strobe,
  output busCondT          cond,
  output logic [REG_W-1:0] regRdata,
  output logic             xferIrq,
  output logic             stopIrq,
  output logic             halt
);

  logic sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclSync)
  );
  i2c_mon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  always_comb begin
    cond.startDet = sclPrev & sclSync & sdaPrev & ~sdaSync;
    cond.stopDet  = sclPrev & sclSync & ~sdaPrev & sdaSync;
    cond.sclRise  = ~sclPrev & sclSync;
  end

  // Enables
  logic [FLAG_N-1:0] enReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      enReg <= '0;
    else if (regWr) enReg <= regWdata[EN_STOP:EN_XFER];
  end

  // Sticky flags: set events win over a clearing write
  logic [FLAG_N-1:0] flagReg;
  logic [FLAG_N-1:0] flagSet;
  logic [FLAG_N-1:0] flagKeep;

  assign flagSet = {strobe.setStop | arbLost, strobe.setBer, xferDone};

  generate
    for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
      assign flagKeep[f] = ~regWr | regWdata[FL_XFER + f];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagReg[f] <= 1'b0;
        else       flagReg[f] <= flagSet[f] | (flagReg[f] & flagKeep[f]);
      end
    end
  endgenerate

  assign regRdata = {flagReg, enReg};
  assign xferIrq  = (flagReg[0] & enReg[0]) | (flagReg[1] & enReg[1]);
  assign stopIrq  = flagReg[2] & enReg[2];
  assign halt     = flagReg[1];

endmodule

// File: rtl/i2c_mon_ctrl.sv
module i2c_mon_ctrl
  import i2c_mon_pkg::*;
#(
  parameter int BITS_PER_FRAME = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  busCondT    cond,
  input  logic       masterMode,
  output ctrlStrobeT strobe
);

  localparam int CNT_W = $clog2(BITS_PER_FRAME + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BITS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] FIRST_LIM = CNT_W'(1);
  localparam logic [CNT_W-1:0] DATA_LIM  = CNT_W'(2);

  logic             busy;
  logic             firstFrame;
  logic [CNT_W-1:0] bitCnt;

  logic anyCond;
  logic posIllegal;
  logic errNow;

  assign anyCond    = cond.startDet | cond.stopDet;
  assign posIllegal = firstFrame ? (bitCnt >= FIRST_LIM) : (bitCnt >= DATA_LIM);
  assign errNow     = (cond.stopDet & masterMode) | (busy & anyCond & posIllegal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      firstFrame <= 1'b0;
      bitCnt     <= '0;
    end else if (errNow) begin
      busy       <= 1'b0;
      firstFrame <= 1'b0;
      bitCnt     <= '0;
    end else if (cond.startDet) begin
      busy       <= 1'b1;
      firstFrame <= 1'b1;
      bitCnt     <= '0;
    end else if (cond.stopDet) begin
      busy       <= 1'b0;
      firstFrame <= 1'b0;
      bitCnt     <= '0;
    end else if (cond.sclRise && busy) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt     <= '0;
        firstFrame <= 1'b0;
      end else begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  assign strobe.setBer  = errNow;
  assign strobe.setStop = cond.stopDet;

endmodule

// File: rtl/i2c_evt_mon.sv
module i2c_evt_mon
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int BITS_PER_FRAME = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       masterMode,
  input  logic       xferDone,
  input  logic       arbLost,
  input  logic       regWr,
  input  logic [5:0] regWdata,
  output logic [5:0] regRdata,
  output logic       xferIrq,
  output logic       stopIrq,
  output logic       halt
);

  busCondT    busCond;
  ctrlStrobeT ctrlStb;
  logic       stopSeen;

  assign stopSeen = busCond.stopDet;

  i2c_mon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .xferDone(xferDone), .arbLost(arbLost),
    .regWr(regWr), .regWdata(regWdata), .strobe(ctrlStb),
    .cond(busCond), .regRdata(regRdata),
    .xferIrq(xferIrq), .stopIrq(stopIrq), .halt(halt)
  );

  i2c_mon_ctrl #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN), .cond(busCond),
    .masterMode(masterMode), .strobe(ctrlStb)
  );

endmodule

// File: rtl/i2c_evt_mon_chk.sv
module i2c_evt_mon_chk (
  input logic       clk,
  input logic       rstN,
  input logic       masterMode,
  input logic       xferDone,
  input logic       arbLost,
  input logic       regWr,
  input logic [5:0] regWdata,
  input logic [5:0] regRdata,
  input logic       stopIrq,
  input logic       halt,
  input logic       stopSeen
);

  a_r2_xfer_sets: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> regRdata[3]);

  a_r11_arb_sets_stop: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |=> regRdata[5]);

  a_r6_stop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> regRdata[5]);

  a_r7_master_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen && masterMode |=> halt);

  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    halt && !(regWr && !regWdata[4]) |=> halt);

  a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regWdata[3] && regRdata[3] |=> regRdata[3]);

  a_r3_stop_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopIrq) |-> regRdata[5] && regRdata[2]);

endmodule

bind i2c_evt_mon i2c_evt_mon_chk u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .xferDone(xferDone),
  .arbLost(arbLost), .regWr(regWr), .regWdata(regWdata),
  .regRdata(regRdata), .stopIrq(stopIrq), .halt(halt), .stopSeen(stopSeen)
);

// File: tb/i2c_evt_mon_bench.sv
module i2c_evt_mon_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1;
  logic       masterMode = 1'b0, xferDone = 1'b0, arbLost = 1'b0;
  logic       regWr = 1'b0;
  logic [5:0] regWdata = '0;
  logic [5:0] regRdata;
  logic       xferIrq, stopIrq, halt;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_evt_mon u_i2c_evt_mon (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .masterMode(masterMode), .xferDone(xferDone), .arbLost(arbLost),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .xferIrq(xferIrq), .stopIrq(stopIrq), .halt(halt)
  );

  task automatic check(input int act, input int exp, input string req);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic d);
    sclIn = c;
    sdaIn = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    pins(1'b0, sdaIn);
    pins(1'b0, d);
    pins(1'b1, d);
  endtask

  task automatic regWrite(input logic [5:0] d);
    @(negedge clk);
    regWr = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // One condition placed after k SCL rises in the first or a later frame
  task automatic runCase(input bit first, input int k, input bit isStop, input bit master);
    bit expErr;
    expErr = (master && isStop) || (first ? (k >= 1) : (k >= 2));
    regWrite(6'b000010);                 // bus-error enable only
    masterMode = master;
    pins(1'b1, 1'b1);
    pins(1'b1, 1'b0);                    // start
    if (!first)
      for (int i = 0; i < 9; i++) pulse(logic'(i % 2));
    for (int i = 0; i < k; i++)
      pulse((i == k - 1) ? !isStop : logic'(i % 2));
    if (isStop) pins(1'b1, 1'b1);
    else        pins(1'b1, 1'b0);
    if (master) check(int'(regRdata[4]), int'(expErr), "R7 master stop error");
    else if (first) check(int'(regRdata[4]), int'(expErr), "R8 first frame error");
    else check(int'(regRdata[4]), int'(expErr), "R9 later frame error");
    check(int'(halt), int'(expErr), "R10 halt follows error");
    check(int'(xferIrq), int'(expErr), "R3 error irq");
    check(int'(regRdata[5]), int'(isStop), "R6 stop flag");
    // back to idle, then clear everything
    masterMode = 1'b0;
    pins(1'b0, sdaIn);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    regWrite(6'b000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(int'(regRdata), 0, "R1 register reset");
    check(int'({xferIrq, stopIrq, halt}), 0, "R1 outputs reset");

    // R2: flag sets with enable low
    xferDone = 1'b1; @(negedge clk); xferDone = 1'b0;
    check(int'(regRdata[3]), 1, "R2 transfer flag set");
    check(int'(xferIrq), 0, "R3 masked transfer irq");
    regWrite(6'b001001);
    check(int'(regRdata), 6'b001001, "R4 write one keeps flag");
    check(int'(xferIrq), 1, "R3 enabled transfer irq");
    regWrite(6'b000001);
    check(int'(regRdata), 6'b000001, "R4 write zero clears flag");
    check(int'(xferIrq), 0, "R3 irq drops after clear");

    // R5: set and clear in the same cycle
    @(negedge clk);
    xferDone = 1'b1; regWr = 1'b1; regWdata = 6'b000000;
    @(negedge clk);
    xferDone = 1'b0; regWr = 1'b0;
    check(int'(regRdata[3]), 1, "R5 set wins over clear");
    regWrite(6'b000000);

    // R11: arbitration lost sets stop flag
    arbLost = 1'b1; @(negedge clk); arbLost = 1'b0;
    check(int'(regRdata[5]), 1, "R11 arb lost stop flag");
    check(int'(stopIrq), 0, "R3 masked stop irq");
    regWrite(6'b100100);
    check(int'(stopIrq), 1, "R3 enabled stop irq");
    regWrite(6'b000000);

    // R10: halt persists until flag cleared
    masterMode = 1'b1;
    pins(1'b1, 1'b0);
    pins(1'b1, 1'b1);
    masterMode = 1'b0;
    repeat (20) @(negedge clk);
    check(int'(halt), 1, "R10 halt persists");
    regWrite(6'b010000);
    check(int'(halt), 1, "R10 write one keeps halt");
    regWrite(6'b000000);
    check(int'(halt), 0, "R10 halt clears");

    // Position sweep
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int k = 0; k < 9; k++)
          for (int s = 0; s < 2; s++)
            if (!(k == 0 && s == 0)) runCase(bit'(f), k, bit'(s), bit'(m));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule